// File: doc/BRIEF.md
# TDM Channel Memory Access Sequencer

This block paces every external RAM access of a 32-slot time-division serial controller. Each channel slot on the line is split into a transmit half followed by a receive half. In every half, the sequencer announces the channel it is serving and the transfer direction. It then raises a demand line and runs a short burst of one, two or three strobed RAM cycles for that channel. A data byte cycle always happens. A descriptor fetch is added when the descriptor logic asks for one. A CPU-requested activation-memory cycle is added when the attention input is high.

All timing comes from one fast system clock that runs at a fixed integer multiple of the line bit clock, so strobe widths scale with the line rate. Each access spends a fixed number of cycles with the address strobe high, a fixed number with the active-low read or write strobe low, and one idle cycle. The read strobe can drive a RAM output enable directly. An access-kind code travels with each access so that surrounding logic can select the address source. The block carries no data itself, and every pin is a plain control or status signal. Every output comes from a flop.

Top module: `tdm_mem_seq`

## Requirements
- R1: A half lasts HALF_CYC = 4*TCLK_DIV = 32 system cycles. `rx_dir_o` is 0 in the transmit half and 1 in the receive half, and it toggles every 32 cycles. `chan_o` never changes when `rx_dir_o` rises.
- R2: `chan_o` advances by one at the start of each transmit half, that is, when `rx_dir_o` falls. After 31 it wraps to 0.
- R3: `demand_o` is 0 during the first DMD_LEAD = TCLK_DIV/2 = 4 cycles of a half and is 1 from cycle 4 until the burst ends.
- R4: Accesses start at cycle ACC_START = DMD_LEAD + TCLK_DIV = 12 of the half and are ACC_CYC = 6 cycles apart. Each access has 2 cycles with `addr_stb_o` high, then 3 cycles with a strobe low, then 1 idle cycle. The address strobe and the data strobes never overlap, and strobes occur only while `demand_o` is 1.
- R5: The number of accesses in a half is 1 + `attn_i` + `desc_need_i`. Both inputs are captured on the clock edge that loads the last output cycle (cycle 31) of the preceding half. Changes after that edge have no effect on the half.
- R6: Accesses run in the order attention, descriptor, data. `acc_kind_o` gives the kind of the access in progress: 3 = attention, 2 = descriptor, 1 = data, 0 = no access.
- R7: Attention and descriptor accesses pulse `rd_n_o`. The data access pulses `rd_n_o` in the transmit half and `wr_n_o` in the receive half. The two strobes are never low together.
- R8: `demand_o` falls at cycle 12 + 6*n of the half, where n is the access count.
- R9: `sys_acc_o` is 1 during the 5 address-and-strobe cycles of the attention access and is 0 at all other times.
- R10: While `rst_n` is low, the outputs are idle: `chan_o`=0, `rx_dir_o`=0, `demand_o`=0, `addr_stb_o`=0, `rd_n_o`=1, `wr_n_o`=1, `sys_acc_o`=0, `acc_kind_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, TCLK_DIV times the line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn_i | input | 1 | CPU attention request: adds an activation-memory access |
| desc_need_i | input | 1 | Adds a descriptor fetch to the next half |
| chan_o | output | 5 | Channel number served in the current half |
| rx_dir_o | output | 1 | 0 = transmit half, 1 = receive half |
| demand_o | output | 1 | RAM demand, covering the whole burst |
| addr_stb_o | output | 1 | Address strobe; the address is valid at its falling edge |
| rd_n_o | output | 1 | Active-low read strobe, usable as a RAM output enable |
| wr_n_o | output | 1 | Active-low write strobe |
| sys_acc_o | output | 1 | High during the activation-memory access |
| acc_kind_o | output | 2 | Kind of access in progress (0 none, 1 data, 2 descriptor, 3 attention) |

## Verification
If the slot counter is wrong, the 32-cycle rhythm of `rx_dir_o` breaks at once, or `chan_o` skips or misses its wrap within one channel period. If the latched request flags or the access index are wrong, the half's burst has the wrong length or order. That shows as a late or early fall of `demand_o`, or as a wrong `acc_kind_o` or `sys_acc_o`, no later than cycle 30 of the same half. A bad phase counter moves the strobe edges within the first six cycles of the burst. The bench compares every output on every cycle of each checked half. It also tests the request capture edge from both sides.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;
  // Kind of RAM access in progress; the code values appear on acc_kind_o.
  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_DESC = 2'd2,
    KIND_ATTN = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/tdm_slot_timer.sv
// Half-slot cycle counter, direction and channel number.
module tdm_slot_timer #(
  parameter int NUM_CH   = 32,
  parameter int HALF_CYC = 32,
  localparam int CHW = $clog2(NUM_CH),
  localparam int CW  = $clog2(HALF_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [CW-1:0]  cyc_o,
  output logic           rx_half_o,
  output logic [CHW-1:0] chan_o,
  output logic           half_end_o
);
  logic [CW-1:0]  cyc_q;
  logic           rx_q;
  logic [CHW-1:0] chan_q;

  assign half_end_o = (cyc_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      rx_q   <= 1'b0;
      chan_q <= '0;
    end else if (half_end_o) begin
      cyc_q <= '0;
      rx_q  <= ~rx_q;
      if (rx_q) chan_q <= (chan_q == CHW'(NUM_CH - 1)) ? '0 : chan_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign cyc_o     = cyc_q;
  assign rx_half_o = rx_q;
  assign chan_o    = chan_q;
endmodule

// File: rtl/tdm_burst_plan.sv
// Latches the per-half requests and maps the access index to its kind.
module tdm_burst_plan
  import tdm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_end_i,
  input  logic       attn_i,
  input  logic       desc_i,
  input  logic [1:0] idx_i,
  output logic [1:0] n_acc_o,
  output acc_kind_e  kind_o
);
  logic attn_q, desc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attn_q <= 1'b0;
      desc_q <= 1'b0;
    end else if (half_end_i) begin
      attn_q <= attn_i;
      desc_q <= desc_i;
    end
  end

  assign n_acc_o = 2'd1 + {1'b0, attn_q} + {1'b0, desc_q};

  // Order: attention, then descriptor, then data.
  always_comb begin
    kind_o = KIND_DATA;
    if (attn_q) begin
      if (idx_i == 2'd0)                 kind_o = KIND_ATTN;
      else if (idx_i == 2'd1 && desc_q)  kind_o = KIND_DESC;
    end else if (desc_q && idx_i == 2'd0) begin
      kind_o = KIND_DESC;
    end
  end
endmodule

// File: rtl/tdm_strobe_gen.sv
// Burst sequencing and registered strobe outputs.
module tdm_strobe_gen
  import tdm_seq_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int HALF_CYC  = 32,
  parameter int DMD_LEAD  = 4,
  parameter int ACC_START = 12,
  parameter int AS_CYC    = 2,
  parameter int STB_CYC   = 3,
  parameter int ACC_CYC   = 6,
  localparam int CHW = $clog2(NUM_CH),
  localparam int CW  = $clog2(HALF_CYC),
  localparam int PW  = $clog2(ACC_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cyc_i,
  input  logic           rx_half_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [1:0]     n_acc_i,
  input  acc_kind_e      kind_i,
  output logic [1:0]     idx_o,
  output logic [CHW-1:0] chan_o,
  output logic           rx_dir_o,
  output logic           demand_o,
  output logic           addr_stb_o,
  output logic           rd_n_o,
  output logic           wr_n_o,
  output logic           sys_acc_o,
  output logic [1:0]     acc_kind_o
);
  logic          busy_q, dmd_q;
  logic [1:0]    idx_q;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dmd_q  <= 1'b0;
      idx_q  <= '0;
      ph_q   <= '0;
    end else begin
      if (cyc_i == CW'(DMD_LEAD - 1)) dmd_q <= 1'b1;
      if (cyc_i == CW'(ACC_START - 1)) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        ph_q   <= '0;
      end else if (busy_q) begin
        if (ph_q == PW'(ACC_CYC - 1)) begin
          ph_q <= '0;
          if (idx_q == 2'(n_acc_i - 2'd1)) begin
            busy_q <= 1'b0;
            dmd_q  <= 1'b0;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign idx_o = idx_q;

  logic in_as, in_stb, in_wr, in_sys;
  always_comb begin
    in_as  = busy_q && (ph_q < PW'(AS_CYC));
    in_stb = busy_q && (ph_q >= PW'(AS_CYC)) && (ph_q < PW'(AS_CYC + STB_CYC));
    in_wr  = (kind_i == KIND_DATA) && rx_half_i;
    in_sys = busy_q && (kind_i == KIND_ATTN) && (ph_q < PW'(AS_CYC + STB_CYC));
  end

  // One output flop stage so every pin, including the RAM enable, is glitch-free.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_o     <= '0;
      rx_dir_o   <= 1'b0;
      demand_o   <= 1'b0;
      addr_stb_o <= 1'b0;
      rd_n_o     <= 1'b1;
      wr_n_o     <= 1'b1;
      sys_acc_o  <= 1'b0;
      acc_kind_o <= KIND_IDLE;
    end else begin
      chan_o     <= chan_i;
      rx_dir_o   <= rx_half_i;
      demand_o   <= dmd_q;
      addr_stb_o <= in_as;
      rd_n_o     <= ~(in_stb && !in_wr);
      wr_n_o     <= ~(in_stb && in_wr);
      sys_acc_o  <= in_sys;
      acc_kind_o <= busy_q ? kind_i : KIND_IDLE;
    end
  end
endmodule

// File: rtl/tdm_mem_seq.sv
// Top: TDM channel memory access sequencer.
module tdm_mem_seq
  import tdm_seq_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int TCLK_DIV = 8,
  parameter int AS_CYC   = 2,
  parameter int STB_CYC  = 3,
  parameter int GAP_CYC  = 1,
  localparam int CHW       = $clog2(NUM_CH),
  localparam int HALF_CYC  = 4 * TCLK_DIV,
  localparam int DMD_LEAD  = TCLK_DIV / 2,
  localparam int ACC_START = DMD_LEAD + TCLK_DIV,
  localparam int ACC_CYC   = AS_CYC + STB_CYC + GAP_CYC,
  localparam int CW        = $clog2(HALF_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           attn_i,
  input  logic           desc_need_i,
  output logic [CHW-1:0] chan_o,
  output logic           rx_dir_o,
  output logic           demand_o,
  output logic           addr_stb_o,
  output logic           rd_n_o,
  output logic           wr_n_o,
  output logic           sys_acc_o,
  output logic [1:0]     acc_kind_o
);
  logic [CW-1:0]  cyc;
  logic           rx_half, half_end;
  logic [CHW-1:0] chan;
  logic [1:0]     n_acc, idx;
  acc_kind_e      kind;

  tdm_slot_timer #(.NUM_CH(NUM_CH), .HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .cyc_o(cyc), .rx_half_o(rx_half),
    .chan_o(chan), .half_end_o(half_end)
  );

  tdm_burst_plan u_plan (
    .clk(clk), .rst_n(rst_n), .half_end_i(half_end), .attn_i(attn_i),
    .desc_i(desc_need_i), .idx_i(idx), .n_acc_o(n_acc), .kind_o(kind)
  );

  tdm_strobe_gen #(
    .NUM_CH(NUM_CH), .HALF_CYC(HALF_CYC), .DMD_LEAD(DMD_LEAD),
    .ACC_START(ACC_START), .AS_CYC(AS_CYC), .STB_CYC(STB_CYC), .ACC_CYC(ACC_CYC)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .rx_half_i(rx_half), .chan_i(chan),
    .n_acc_i(n_acc), .kind_i(kind), .idx_o(idx),
    .chan_o(chan_o), .rx_dir_o(rx_dir_o), .demand_o(demand_o),
    .addr_stb_o(addr_stb_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .sys_acc_o(sys_acc_o), .acc_kind_o(acc_kind_o)
  );
endmodule

// File: rtl/tdm_mem_seq_chk.sv
// Port-level protocol checker, bound into tdm_mem_seq.
module tdm_mem_seq_chk #(
  parameter int NUM_CH = 32,
  localparam int CHW = $clog2(NUM_CH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CHW-1:0] chan_o,
  input logic           rx_dir_o,
  input logic           demand_o,
  input logic           addr_stb_o,
  input logic           rd_n_o,
  input logic           wr_n_o,
  input logic           sys_acc_o,
  input logic [1:0]     acc_kind_o
);
  logic [CHW-1:0] prev_ch, step_ch;
  always_ff @(posedge clk) prev_ch <= chan_o;
  assign step_ch = (prev_ch == CHW'(NUM_CH - 1)) ? '0 : prev_ch + 1'b1;

  assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  assert_write_in_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> rx_dir_o);
  assert_strobe_in_demand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb_o || !rd_n_o || !wr_n_o) |-> demand_o);
  assert_as_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_o |-> (rd_n_o && wr_n_o));
  assert_sysacc_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_acc_o |-> (acc_kind_o == 2'd3 && demand_o));
  assert_chan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_o != $past(chan_o)) |-> ($fell(rx_dir_o) && chan_o == step_ch));
  assert_rx_same_chan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dir_o) |-> $stable(chan_o));
endmodule

bind tdm_mem_seq tdm_mem_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_o(chan_o), .rx_dir_o(rx_dir_o),
  .demand_o(demand_o), .addr_stb_o(addr_stb_o), .rd_n_o(rd_n_o),
  .wr_n_o(wr_n_o), .sys_acc_o(sys_acc_o), .acc_kind_o(acc_kind_o)
);

// File: tb/tdm_mem_seq_bench.sv
module tdm_mem_seq_bench;
  localparam int NCH = 32, HALF = 32, LEAD = 4, START = 12, ASC = 2, STBC = 3, ACC = 6;

  logic clk = 1'b0, rst_n = 1'b0, attn = 1'b0, desc = 1'b0;
  logic [4:0] chan;
  logic rx_dir, demand, astb, rd_n, wr_n, sys_acc;
  logic [1:0] kind;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit cur_a = 1'b0, cur_d = 1'b0, cur_rx = 1'b0;
  int exp_ch = 0;

  always #10 clk = ~clk;

  tdm_mem_seq u_tdm_mem_seq (
    .clk(clk), .rst_n(rst_n), .attn_i(attn), .desc_need_i(desc),
    .chan_o(chan), .rx_dir_o(rx_dir), .demand_o(demand), .addr_stb_o(astb),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .sys_acc_o(sys_acc), .acc_kind_o(kind)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare every output at output cycle c of the current half.
  task automatic check_cycle(input int c);
    int n, end_c, rel, idx, ph, kl[3], pos, ek;
    bit e_dmd, e_as, e_rd, e_wr, e_sys, stb;
    n = 1 + int'(cur_a) + int'(cur_d);
    end_c = START + n * ACC;
    pos = 0;
    if (cur_a) begin kl[pos] = 3; pos++; end
    if (cur_d) begin kl[pos] = 2; pos++; end
    kl[pos] = 1;
    e_dmd = (c >= LEAD) && (c < end_c);
    ek = 0; e_as = 0; e_rd = 0; e_wr = 0; e_sys = 0;
    if (c >= START && c < end_c) begin
      rel = c - START; idx = rel / ACC; ph = rel % ACC;
      ek = kl[idx];
      e_as = ph < ASC;
      stb = (ph >= ASC) && (ph < ASC + STBC);
      e_wr = stb && ek == 1 && cur_rx;
      e_rd = stb && !(ek == 1 && cur_rx);
      e_sys = (ek == 3) && (ph < ASC + STBC);
    end
    chk(chan == 5'(exp_ch), "R2 channel number", int'(chan), exp_ch);
    chk(rx_dir == cur_rx, "R1 direction", int'(rx_dir), int'(cur_rx));
    chk(demand == e_dmd, (c < START) ? "R3 demand rise" : "R8 demand fall",
        int'(demand), int'(e_dmd));
    chk(astb == e_as, "R4 address strobe", int'(astb), int'(e_as));
    chk(rd_n == !e_rd, "R7 read strobe", int'(rd_n), int'(!e_rd));
    chk(wr_n == !e_wr, "R7 write strobe", int'(wr_n), int'(!e_wr));
    chk(sys_acc == e_sys, "R9 system access", int'(sys_acc), int'(e_sys));
    chk(kind == 2'(ek), "R6 access kind/R5 count", int'(kind), ek);
  endtask

  // Check one half. Drive (ja,jd) at cycle 0, then (a,d) at cycle set_c.
  task automatic run_half(input bit a, input bit d, input bit ja, input bit jd, input int set_c);
    for (int c = 0; c < HALF; c++) begin
      if (c == 0) begin attn = ja; desc = jd; end
      if (c == set_c) begin attn = a; desc = d; end
      check_cycle(c);
      @(negedge clk);
    end
    if (set_c <= HALF - 2) begin cur_a = a; cur_d = d; end
    else begin cur_a = ja; cur_d = jd; end
    if (cur_rx) exp_ch = (exp_ch + 1) % NCH;
    cur_rx = !cur_rx;
  endtask

  task automatic test_reset_r10();
    repeat (3) @(negedge clk);
    chk(chan == 0 && rx_dir == 0, "R10 reset chan/dir", int'(chan), 0);
    chk(demand == 0 && astb == 0 && sys_acc == 0, "R10 reset demand/strobe",
        int'(demand), 0);
    chk(rd_n == 1 && wr_n == 1, "R10 reset rd_n/wr_n", int'({rd_n, wr_n}), 3);
    chk(kind == 0, "R10 reset kind", int'(kind), 0);
  endtask

  task automatic test_single_data();   // R5 one access, both directions
    run_half(0, 0, 0, 0, 0);
    run_half(0, 0, 0, 0, 0);
  endtask

  task automatic test_descriptor();    // R5/R6 two accesses
    run_half(1'b0, 1'b1, 1'b0, 1'b1, 0);
    run_half(1'b0, 1'b1, 1'b0, 1'b1, 0);
    run_half(0, 0, 0, 0, 0);
  endtask

  task automatic test_attention();     // R9 attention then data
    run_half(1'b1, 1'b0, 1'b1, 1'b0, 0);
    run_half(1'b1, 1'b0, 1'b1, 1'b0, 0);
    run_half(1'b1, 1'b1, 1'b1, 1'b1, 0);
  endtask

  task automatic test_full_burst();    // R6/R8 three accesses in both halves
    run_half(1'b1, 1'b1, 1'b1, 1'b1, 0);
    run_half(0, 0, 0, 0, 0);
  endtask

  task automatic test_capture_edge();  // R5 capture boundary at cycle 30/31
    run_half(1'b1, 1'b0, 1'b0, 1'b1, HALF - 2);
    run_half(1'b0, 1'b0, 1'b1, 1'b1, HALF - 1);
    run_half(0, 0, 0, 0, 0);
    run_half(0, 0, 0, 0, 0);
  endtask

  task automatic test_wrap_r2();       // R2 channel 31 -> 0
    int cnt = 0;
    while (!(exp_ch == 1 && !cur_rx && cnt > 2)) begin
      run_half(1'(cnt % 3 == 0), 1'(cnt % 2), 1'(cnt % 3 == 0), 1'(cnt % 2), 0);
      cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset_r10();
    rst_n = 1'b1;
    while (rx_dir !== 1'b1) @(negedge clk);
    cur_rx = 1'b1; exp_ch = 0; cur_a = 0; cur_d = 0;
    test_single_data();
    test_descriptor();
    test_attention();
    test_full_burst();
    test_capture_edge();
    test_wrap_r2();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule